// File: doc/BRIEF.md
# Next Fetch Address Selector

This block holds the program counter of a five-stage 32-bit pipelined processor and decides, every clock, which address is fetched next. It picks between the sequential successor, a PC-relative branch target, a target taken from a register, an absolute jump built from the instruction's jump field, and three fixed vectors: the reset vector and two exception entry points.

Branches are resolved in the decode stage. The two register operands read there are compared for equality. While a branch sits in decode, the PC already holds the address of the instruction after it, which is being fetched. That instruction is the delay slot and always executes. The branch offset is therefore added to the current PC, which equals the branch's own address plus four.

A stall input freezes the PC. A pending interrupt forces the second exception vector whenever the PC is free to advance. The combinational fetch address output shows, ahead of the edge, the value the PC will take.

Top module: `fetch_addr_sel`

## Requirements
- R1: While `rst` is high, the PC loads 0x80000000 at every rising edge and `fetch_addr_o` shows 0x80000000, whatever `stall_i`, `irq_i` or `sel_i` hold.
- R2: With select code 0 the PC advances by 4, and `pc_plus4_o` always equals `pc_o` + 4.
- R3: With select code 1 and `rs_val_i` equal to `rt_val_i`, the next PC is `pc_o` plus the sign-extended `jfield_i[15:0]` shifted left by two. Because `pc_o` is the delay-slot address, that instruction is fetched before the target.
- R4: With select code 1 and unequal operands, the next PC is `pc_o` + 4.
- R5: With select code 2, the next PC is `rs_val_i` with bits [1:0] cleared.
- R6: With select code 3, the next PC is `pc_o[31:28]`, then `jfield_i[25:0]`, then two zero bits.
- R7: Select codes 4, 5 and 6 load 0x80000000, 0x80000040 and 0x80000080.
- R8: The unused select code 7 behaves as code 0.
- R9: While `stall_i` is high, the PC keeps its value and `fetch_addr_o` equals `pc_o`, even if `irq_i` is high.
- R10: When `irq_i` is high and `stall_i` is low, the next PC is 0x80000080 regardless of `sel_i`.
- R11: Outside reset, the value on `fetch_addr_o` before a rising edge is the value `pc_o` holds after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Hold the PC this cycle |
| irq_i | input | 1 | Pending interrupt request |
| sel_i | input | 3 | Next-address select code (0 to 6, 7 treated as 0) |
| jfield_i | input | 26 | Jump field of the decode-stage instruction; bits [15:0] are the branch immediate |
| rs_val_i | input | 32 | First register operand; also the register jump target |
| rt_val_i | input | 32 | Second register operand for the branch compare |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | Current PC plus four |
| fetch_addr_o | output | 32 | Address the PC takes at the next edge |

## Verification
Branches are tried with a positive and a negative offset under equal operands, and with unequal operands. This separates a correct sign extension and word shift from a wrong one, and a decided compare from one ignored. The absolute jump is taken from a PC whose bit 28 is set, with an all-ones jump field, so it shows whether the right upper PC bits are kept. A misaligned register value shows whether bits [1:0] are cleared. Stall is held together with an interrupt and a jump select, and the interrupt is raised under a register-jump select, which fixes the priority order of reset, stall, interrupt and decoded select.

// File: rtl/fas_pkg.sv
package fas_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_SEQ   = 3'd0,
      SEL_BR    = 3'd1,
      SEL_REG   = 3'd2,
      SEL_ABS   = 3'd3,
      SEL_RST   = 3'd4,
      SEL_VEC_A = 3'd5,
      SEL_VEC_B = 3'd6
   } next_sel_e;
endpackage

// File: rtl/fas_eq_cmp.sv
module fas_eq_cmp #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         eq_o
);
   logic [W-1:0] diff;
   assign diff = a_i ^ b_i;
   assign eq_o = ~(|diff);
endmodule

// File: rtl/fas_targets.sv
module fas_targets #(
   parameter int XLEN          = 32,
   parameter int JIDX_W        = 26,
   parameter int IMM_W         = 16,
   parameter bit REG_TGT_ALIGN = 1'b1
) (
   input  logic [XLEN-1:0]   pc_i,
   input  logic [JIDX_W-1:0] jfield_i,
   input  logic [XLEN-1:0]   rs_val_i,
   output logic [XLEN-1:0]   pc_plus4_o,
   output logic [XLEN-1:0]   br_tgt_o,
   output logic [XLEN-1:0]   abs_tgt_o,
   output logic [XLEN-1:0]   reg_tgt_o
);
   localparam int PAGE_W = XLEN - JIDX_W - 2;
   localparam int SEXT_W = XLEN - IMM_W - 2;

   logic [IMM_W-1:0] imm;
   logic [XLEN-1:0]  br_off;

   assign imm        = jfield_i[IMM_W-1:0];
   assign br_off     = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
   assign pc_plus4_o = pc_i + XLEN'(4);
   assign br_tgt_o   = pc_i + br_off;
   assign abs_tgt_o  = {pc_i[XLEN-1 -: PAGE_W], jfield_i, 2'b00};

   generate
      if (REG_TGT_ALIGN) begin : g_align
         assign reg_tgt_o = rs_val_i & ~XLEN'(3);
      end else begin : g_raw
         assign reg_tgt_o = rs_val_i;
      end
   endgenerate
endmodule

// File: rtl/fas_pc_reg.sv
module fas_pc_reg #(
   parameter int              XLEN    = 32,
   parameter logic [XLEN-1:0] RST_VEC = 32'h8000_0000
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            hold_i,
   input  logic [XLEN-1:0] nxt_i,
   output logic [XLEN-1:0] pc_o
);
   logic [XLEN-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (rst)          pc_q <= RST_VEC;
      else if (!hold_i) pc_q <= nxt_i;
   end

   assign pc_o = pc_q;

   p_reset_load_r1: assert property (@(posedge clk) rst |=> pc_q == RST_VEC);
   p_hold_keeps_r9: assert property (@(posedge clk) disable iff (rst)
      hold_i |=> pc_q == $past(pc_q));
endmodule

// File: rtl/fetch_addr_sel.sv
module fetch_addr_sel #(
   parameter int              XLEN          = 32,
   parameter int              JIDX_W        = 26,
   parameter int              IMM_W         = 16,
   parameter bit              REG_TGT_ALIGN = 1'b1,
   parameter logic [XLEN-1:0] RST_VEC       = 32'h8000_0000,
   parameter logic [XLEN-1:0] VEC_A         = 32'h8000_0040,
   parameter logic [XLEN-1:0] VEC_B         = 32'h8000_0080
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     stall_i,
   input  logic                     irq_i,
   input  logic [fas_pkg::SEL_W-1:0] sel_i,
   input  logic [JIDX_W-1:0]        jfield_i,
   input  logic [XLEN-1:0]          rs_val_i,
   input  logic [XLEN-1:0]          rt_val_i,
   output logic [XLEN-1:0]          pc_o,
   output logic [XLEN-1:0]          pc_plus4_o,
   output logic [XLEN-1:0]          fetch_addr_o
);
   import fas_pkg::*;

   generate
      if (JIDX_W + 2 >= XLEN) begin : g_bad_jidx
         $error("jump field leaves no upper PC bits");
      end
      if (IMM_W > JIDX_W || IMM_W + 2 >= XLEN) begin : g_bad_imm
         $error("branch immediate width does not fit");
      end
   endgenerate

   logic [XLEN-1:0] pc, seq_a, br_a, abs_a, reg_a, dec_a;
   logic            ops_eq;

   fas_eq_cmp #(.W(XLEN)) u_cmp (
      .a_i  (rs_val_i),
      .b_i  (rt_val_i),
      .eq_o (ops_eq)
   );

   fas_targets #(
      .XLEN(XLEN), .JIDX_W(JIDX_W), .IMM_W(IMM_W), .REG_TGT_ALIGN(REG_TGT_ALIGN)
   ) u_tgt (
      .pc_i       (pc),
      .jfield_i   (jfield_i),
      .rs_val_i   (rs_val_i),
      .pc_plus4_o (seq_a),
      .br_tgt_o   (br_a),
      .abs_tgt_o  (abs_a),
      .reg_tgt_o  (reg_a)
   );

   always_comb begin
      unique case (sel_i)
         SEL_SEQ:   dec_a = seq_a;
         SEL_BR:    dec_a = ops_eq ? br_a : seq_a;
         SEL_REG:   dec_a = reg_a;
         SEL_ABS:   dec_a = abs_a;
         SEL_RST:   dec_a = RST_VEC;
         SEL_VEC_A: dec_a = VEC_A;
         SEL_VEC_B: dec_a = VEC_B;
         default:   dec_a = seq_a;
      endcase
   end

   always_comb begin
      if (rst)          fetch_addr_o = RST_VEC;
      else if (stall_i) fetch_addr_o = pc;
      else if (irq_i)   fetch_addr_o = VEC_B;
      else              fetch_addr_o = dec_a;
   end

   fas_pc_reg #(.XLEN(XLEN), .RST_VEC(RST_VEC)) u_pc (
      .clk    (clk),
      .rst    (rst),
      .hold_i (stall_i),
      .nxt_i  (dec_a_or_irq()),
      .pc_o   (pc)
   );

   function automatic logic [XLEN-1:0] dec_a_or_irq();
      return irq_i ? VEC_B : dec_a;
   endfunction

   assign pc_o       = pc;
   assign pc_plus4_o = seq_a;

   p_fetch_match_r11: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> pc == $past(fetch_addr_o));
   p_irq_vector_r10: assert property (@(posedge clk) disable iff (rst)
      (irq_i && !stall_i) |=> pc == VEC_B);
   p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
      (!stall_i && !irq_i && sel_i == SEL_SEQ) |=> pc == $past(pc) + XLEN'(4));
   p_untaken_r4: assert property (@(posedge clk) disable iff (rst)
      (!stall_i && !irq_i && sel_i == SEL_BR && rs_val_i != rt_val_i)
      |=> pc == $past(pc) + XLEN'(4));

   generate
      if (REG_TGT_ALIGN) begin : g_align_chk
         p_word_aligned_r5: assert property (@(posedge clk) disable iff (rst)
            pc[1:0] == 2'b00);
      end
   endgenerate
endmodule

// File: tb/fetch_addr_sel_tb_top.sv
module fetch_addr_sel_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stall_i = 1'b0;
   logic        irq_i = 1'b0;
   logic [2:0]  sel_i = 3'd0;
   logic [25:0] jfield_i = '0;
   logic [31:0] rs_val_i = '0;
   logic [31:0] rt_val_i = '0;
   logic [31:0] pc_o, pc_plus4_o, fetch_addr_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [31:0] pre_fa;

   always #5 clk = ~clk;

   fetch_addr_sel dut_i (
      .clk(clk), .rst(rst), .stall_i(stall_i), .irq_i(irq_i), .sel_i(sel_i),
      .jfield_i(jfield_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
      .pc_o(pc_o), .pc_plus4_o(pc_plus4_o), .fetch_addr_o(fetch_addr_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // Called at a falling edge: sets inputs, samples fetch address, crosses one rising edge.
   task automatic apply(input logic [2:0] s, input logic [25:0] jf, input logic [31:0] a,
                        input logic [31:0] b, input logic irq, input logic stl);
      sel_i = s; jfield_i = jf; rs_val_i = a; rt_val_i = b; irq_i = irq; stall_i = stl;
      #1 pre_fa = fetch_addr_o;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (2) @(negedge clk);
      chk("R1 reset pc", pc_o, 32'h8000_0000);
      chk("R1 reset fetch", fetch_addr_o, 32'h8000_0000);
      rst = 1'b0;
      apply(3'd0, '0, 0, 0, 0, 0);
      chk("R11 fetch before edge", pre_fa, 32'h8000_0004);
      chk("R2 sequential", pc_o, 32'h8000_0004);
      chk("R2 pc plus 4", pc_plus4_o, 32'h8000_0008);
   endtask

   task automatic t_branch();
      apply(3'd1, 26'h0010, 32'd5, 32'd5, 0, 0);
      chk("R3 taken forward", pc_o, 32'h8000_0044);
      apply(3'd1, 26'h3FFFFFE, 32'hA5, 32'hA5, 0, 0);
      chk("R3 taken backward", pc_o, 32'h8000_003C);
      apply(3'd1, 26'h0010, 32'd5, 32'd6, 0, 0);
      chk("R4 not taken", pc_o, 32'h8000_0040);
   endtask

   task automatic t_jumps();
      apply(3'd2, '0, 32'h9000_1237, 0, 0, 0);
      chk("R5 register jump aligned", pc_o, 32'h9000_1234);
      apply(3'd3, 26'h3FF_FFFF, 0, 0, 0, 0);
      chk("R6 absolute jump", pc_o, 32'h9FFF_FFFC);
   endtask

   task automatic t_vectors();
      apply(3'd5, '0, 0, 0, 0, 0);
      chk("R7 vector A", pc_o, 32'h8000_0040);
      apply(3'd4, '0, 0, 0, 0, 0);
      chk("R7 reset vector select", pc_o, 32'h8000_0000);
      apply(3'd6, '0, 0, 0, 0, 0);
      chk("R7 vector B", pc_o, 32'h8000_0080);
      apply(3'd7, '0, 0, 0, 0, 0);
      chk("R8 code 7 sequential", pc_o, 32'h8000_0084);
   endtask

   task automatic t_stall_irq();
      apply(3'd3, 26'h123_4567, 0, 0, 1, 1);
      chk("R9 stall fetch equals pc", pre_fa, 32'h8000_0084);
      chk("R9 stall holds pc", pc_o, 32'h8000_0084);
      apply(3'd2, '0, 32'h0000_1000, 0, 1, 0);
      chk("R11 irq fetch before edge", pre_fa, 32'h8000_0080);
      chk("R10 irq overrides select", pc_o, 32'h8000_0080);
      rst = 1'b1;
      apply(3'd3, 26'h0FF, 0, 0, 1, 1);
      chk("R1 reset over stall", pc_o, 32'h8000_0000);
      rst = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_branch();
      t_jumps();
      t_vectors();
      t_stall_irq();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule